// File: doc/BRIEF.md
# USB Packet Identifier and Token Field Decoder

This block sits behind a serial receiver that has already removed line coding and stuffed bits. It takes the packet as a stream of bytes, with a marker on the first byte and a marker on the last byte. The first byte is the packet identifier. The decoder checks that identifier for consistency and sorts the packet into one of four groups: token, data, handshake or start-of-frame.

For token and start-of-frame packets it also takes in the two payload bytes that follow. From a token it extracts the 7-bit device address and the 4-bit endpoint. It compares the address with the address programmed for this device and raises a one-cycle hit strobe when they match. From a start-of-frame packet it extracts the 11-bit frame number. A token or start-of-frame packet whose length is not exactly three bytes is reported as a length error. The 5-bit check field in the payload is passed over here, because a separate checker handles it. Data and handshake payloads are passed over as well.

Every output is registered. Each result appears in the cycle after the clock edge that accepted the byte it belongs to. The asynchronous active-low reset is released synchronously inside the block, two clock edges after the reset input rises.

Top module: `usb_pid_tok_dec`

## Requirements
- R1: After reset, pid_ok, pid_bad, tok_stb, sof_stb, addr_hit and len_err are low, and tok_addr, tok_endp, frame_num, pid_class and pid_type are all zero.
- R2: A byte accepted with in_first set is a packet identifier. It is valid only when bits 7:4 equal the bitwise inverse of bits 3:0 and bits 1:0 are not 00. One cycle later exactly one of pid_ok or pid_bad pulses for one cycle. Neither pulses at any other time.
- R3: On each accepted first byte, pid_type loads bits 3:0. pid_class loads a group code from those bits: 0 for token (low bits 01 and nibble other than 0101), 3 for start-of-frame (nibble 0101), 1 for data (low bits 11) and 2 for handshake (low bits 10). The token nibbles are OUT 0001, IN 1001 and SETUP 1101.
- R4: The token payload is 16 bits, least significant byte first. Bits 6:0 are the address, bits 10:7 are the endpoint and bits 15:11 are the check field. When the third byte of a valid token carries in_last, tok_stb pulses one cycle later, and tok_addr and tok_endp take the new values in that same cycle. At any other time tok_addr and tok_endp keep their values.
- R5: addr_hit pulses together with tok_stb when the extracted address equals dev_addr as sampled with the third byte. It never pulses for a start-of-frame packet.
- R6: For a valid start-of-frame packet of exactly three bytes, sof_stb pulses and frame_num takes payload bits 10:0. tok_stb does not pulse, and the token fields do not change.
- R7: A valid token or start-of-frame packet whose in_last comes on its first or second byte, or on any byte after the third, pulses len_err one cycle after that byte. No tok_stb or sof_stb follows, and no field changes.
- R8: A first byte that arrives while a token or start-of-frame packet is still open pulses len_err together with the new identifier's pid_ok or pid_bad.
- R9: Bytes that follow an invalid identifier or a data or handshake identifier are ignored, and so are bytes without in_first outside a packet. They cause no strobe and no field change.
- R10: Cycles with in_valid low have no effect. A token may be spread over cycles with idle gaps between its bytes and still decodes as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | ADDR_W | Programmed address of this device |
| in_valid | input | 1 | Byte on in_data is accepted this cycle |
| in_data | input | 8 | Packet byte |
| in_first | input | 1 | Byte is the packet identifier (first byte) |
| in_last | input | 1 | Byte is the last of the packet |
| pid_ok | output | 1 | Pulse: identifier was consistent |
| pid_bad | output | 1 | Pulse: identifier was rejected |
| pid_class | output | 2 | Group of the latest identifier |
| pid_type | output | 4 | Low nibble of the latest identifier |
| tok_stb | output | 1 | Pulse: token decoded |
| sof_stb | output | 1 | Pulse: start-of-frame decoded |
| addr_hit | output | 1 | Pulse: decoded token is addressed to this device |
| len_err | output | 1 | Pulse: token or start-of-frame length was wrong |
| tok_addr | output | ADDR_W | Address of the last decoded token |
| tok_endp | output | ENDP_W | Endpoint of the last decoded token |
| frame_num | output | ADDR_W+ENDP_W | Frame number of the last start-of-frame |

## Verification
The hardest situations to reach are the packets that break off early: a token cut short by a new identifier, or one that runs past three bytes. In both cases the block must report the error while leaving the previously decoded fields unchanged. The stimulus first completes a good token so that known field values are in place. It then sends the short, interrupted and over-long packets and checks that the fields still hold the earlier values. The identifier check is covered by sweeping all 256 byte values, each sent as a one-byte packet. The address and endpoint paths are covered by sweeping every address with rotating endpoints and identifier codes, against two different programmed addresses.

// File: rtl/usbdec_pkg.sv
package usbdec_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int PAY_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    CLS_TOKEN = 2'd0,
    CLS_DATA  = 2'd1,
    CLS_HSK   = 2'd2,
    CLS_SOF   = 2'd3
  } pkt_class_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PAY1 = 2'd1,
    SQ_PAY2 = 2'd2,
    SQ_OVER = 2'd3
  } seq_state_t;
endpackage

// File: rtl/usbdec_pid_chk.sv
module usbdec_pid_chk
  import usbdec_pkg::*;
(
  input  logic [BYTE_W-1:0] pid_byte,
  output logic              pid_good,
  output pkt_class_t        pid_cls,
  output logic [NIB_W-1:0]  pid_nib
);
  logic [NIB_W-1:0] hi_nib;

  always_comb begin
    pid_nib  = pid_byte[NIB_W-1:0];
    hi_nib   = pid_byte[BYTE_W-1:NIB_W];
    pid_good = (hi_nib == ~pid_nib) && (pid_nib[1:0] != 2'b00);
    unique case (pid_nib[1:0])
      2'b01:   pid_cls = (pid_nib == 4'b0101) ? CLS_SOF : CLS_TOKEN;
      2'b11:   pid_cls = CLS_DATA;
      2'b10:   pid_cls = CLS_HSK;
      default: pid_cls = CLS_TOKEN;
    endcase
  end
endmodule

// File: rtl/usbdec_seq.sv
module usbdec_seq
  import usbdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sn,
  input  logic       in_valid,
  input  logic       in_first,
  input  logic       in_last,
  input  logic       pid_good,
  input  pkt_class_t pid_cls,
  output logic       cap_b1,
  output logic       fin_tok,
  output logic       fin_sof,
  output logic       len_bad
);
  seq_state_t st_q, st_d;
  logic       sof_q, sof_d;
  logic       opens;

  always_comb begin
    st_d    = st_q;
    sof_d   = sof_q;
    cap_b1  = 1'b0;
    fin_tok = 1'b0;
    fin_sof = 1'b0;
    len_bad = 1'b0;
    opens   = pid_good && ((pid_cls == CLS_TOKEN) || (pid_cls == CLS_SOF));
    if (in_valid) begin
      if (in_first) begin
        len_bad = (st_q != SQ_IDLE) || (opens && in_last);
        sof_d   = (pid_cls == CLS_SOF);
        st_d    = (opens && !in_last) ? SQ_PAY1 : SQ_IDLE;
      end else begin
        unique case (st_q)
          SQ_PAY1: begin
            cap_b1 = 1'b1;
            if (in_last) begin
              len_bad = 1'b1;
              st_d    = SQ_IDLE;
            end else begin
              st_d = SQ_PAY2;
            end
          end
          SQ_PAY2: begin
            if (in_last) begin
              fin_tok = !sof_q;
              fin_sof = sof_q;
              st_d    = SQ_IDLE;
            end else begin
              st_d = SQ_OVER;
            end
          end
          SQ_OVER: begin
            if (in_last) begin
              len_bad = 1'b1;
              st_d    = SQ_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q  <= SQ_IDLE;
      sof_q <= 1'b0;
    end else if (in_valid) begin
      st_q  <= st_d;
      sof_q <= sof_d;
    end
  end

  // R10: an idle cycle leaves the sequencer where it was
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !in_valid |=> (st_q == $past(st_q)));

  // R9: a stray non-first byte outside a packet produces no event
  a_r9_orphan_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == SQ_IDLE && in_valid && !in_first) |-> !(cap_b1 || fin_tok || fin_sof || len_bad));

  // R4: a completed packet returns the sequencer to idle
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    (fin_tok || fin_sof) |=> (st_q == SQ_IDLE));
endmodule

// File: rtl/usbdec_fields.sv
module usbdec_fields
  import usbdec_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int ENDP_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_sn,
  input  logic [BYTE_W-1:0]        in_data,
  input  logic [ADDR_W-1:0]        dev_addr,
  input  logic                     cap_b1,
  input  logic                     fin_tok,
  input  logic                     fin_sof,
  output logic                     tok_stb,
  output logic                     sof_stb,
  output logic                     addr_hit,
  output logic [ADDR_W-1:0]        tok_addr,
  output logic [ENDP_W-1:0]        tok_endp,
  output logic [ADDR_W+ENDP_W-1:0] frame_num
);
  localparam int FRAME_W = ADDR_W + ENDP_W;

  logic [BYTE_W-1:0]  b1_q;
  logic [PAY_W-1:0]   payload;
  logic [ADDR_W-1:0]  addr_d;
  logic [ENDP_W-1:0]  endp_d;
  logic [FRAME_W-1:0] frame_d;
  logic               hit_d;

  always_comb begin
    payload = {in_data, b1_q};
    addr_d  = payload[ADDR_W-1:0];
    endp_d  = payload[ADDR_W +: ENDP_W];
    frame_d = payload[FRAME_W-1:0];
    hit_d   = fin_tok && (addr_d == dev_addr);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      b1_q      <= '0;
      tok_stb   <= 1'b0;
      sof_stb   <= 1'b0;
      addr_hit  <= 1'b0;
      tok_addr  <= '0;
      tok_endp  <= '0;
      frame_num <= '0;
    end else begin
      tok_stb  <= fin_tok;
      sof_stb  <= fin_sof;
      addr_hit <= hit_d;
      if (cap_b1) begin
        b1_q <= in_data;
      end
      if (fin_tok) begin
        tok_addr <= addr_d;
        tok_endp <= endp_d;
      end
      if (fin_sof) begin
        frame_num <= frame_d;
      end
    end
  end

  // R5: a hit only comes with a token and the address programmed at that time
  a_r5_hit_is_token: assert property (@(posedge clk) disable iff (!rst_sn)
    addr_hit |-> (tok_stb && (tok_addr == $past(dev_addr))));

  // R4: token fields change only with the token strobe
  a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !tok_stb |-> ($stable(tok_addr) && $stable(tok_endp)));

  // R6: frame number changes only with the start-of-frame strobe
  a_r6_frame_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !sof_stb |-> $stable(frame_num));

  // R6: a packet is never decoded as both kinds
  a_r6_one_kind: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({tok_stb, sof_stb}));
endmodule

// File: rtl/usb_pid_tok_dec.sv
module usb_pid_tok_dec
  import usbdec_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int ENDP_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        dev_addr,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  input  logic                     in_first,
  input  logic                     in_last,
  output logic                     pid_ok,
  output logic                     pid_bad,
  output logic [1:0]               pid_class,
  output logic [3:0]               pid_type,
  output logic                     tok_stb,
  output logic                     sof_stb,
  output logic                     addr_hit,
  output logic                     len_err,
  output logic [ADDR_W-1:0]        tok_addr,
  output logic [ENDP_W-1:0]        tok_endp,
  output logic [ADDR_W+ENDP_W-1:0] frame_num
);
  logic [1:0]       rst_pipe;
  logic             rst_sn;
  logic             pid_good;
  pkt_class_t       pid_cls;
  logic [NIB_W-1:0] pid_nib;
  logic             cap_b1, fin_tok, fin_sof, len_bad;
  logic             pid_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  usbdec_pid_chk u_chk (
    .pid_byte (in_data),
    .pid_good (pid_good),
    .pid_cls  (pid_cls),
    .pid_nib  (pid_nib)
  );

  usbdec_seq u_seq (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .in_valid (in_valid),
    .in_first (in_first),
    .in_last  (in_last),
    .pid_good (pid_good),
    .pid_cls  (pid_cls),
    .cap_b1   (cap_b1),
    .fin_tok  (fin_tok),
    .fin_sof  (fin_sof),
    .len_bad  (len_bad)
  );

  usbdec_fields #(.ADDR_W(ADDR_W), .ENDP_W(ENDP_W)) u_fld (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .in_data   (in_data),
    .dev_addr  (dev_addr),
    .cap_b1    (cap_b1),
    .fin_tok   (fin_tok),
    .fin_sof   (fin_sof),
    .tok_stb   (tok_stb),
    .sof_stb   (sof_stb),
    .addr_hit  (addr_hit),
    .tok_addr  (tok_addr),
    .tok_endp  (tok_endp),
    .frame_num (frame_num)
  );

  assign pid_take = in_valid && in_first;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pid_ok    <= 1'b0;
      pid_bad   <= 1'b0;
      len_err   <= 1'b0;
      pid_class <= 2'b00;
      pid_type  <= 4'h0;
    end else begin
      pid_ok  <= pid_take && pid_good;
      pid_bad <= pid_take && !pid_good;
      len_err <= len_bad;
      if (pid_take) begin
        pid_class <= pid_cls;
        pid_type  <= pid_nib;
      end
    end
  end

  // R2: identifier verdicts only follow an accepted first byte
  a_r2_after_first: assert property (@(posedge clk) disable iff (!rst_sn)
    (pid_ok || pid_bad) |-> $past(in_valid && in_first));

  // R2: an accepted first byte always yields exactly one verdict
  a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && in_first) |=> (pid_ok ^ pid_bad));

  // R7: a length error and a completed decode never share a cycle
  a_r7_err_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    len_err |-> !(tok_stb || sof_stb));
endmodule

// File: tb/sim_usb_pid_tok_dec.sv
`timescale 1ns/1ps
module sim_usb_pid_tok_dec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  dev_addr;
  logic        in_valid, in_first, in_last;
  logic [7:0]  in_data;
  logic        pid_ok, pid_bad, tok_stb, sof_stb, addr_hit, len_err;
  logic [1:0]  pid_class;
  logic [3:0]  pid_type;
  logic [6:0]  tok_addr;
  logic [3:0]  tok_endp;
  logic [10:0] frame_num;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [6:0]  ex_addr;
  logic [3:0]  ex_endp;
  logic [10:0] ex_frame;

  always #5 clk = ~clk;

  usb_pid_tok_dec u0 (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
    .in_valid(in_valid), .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .pid_ok(pid_ok), .pid_bad(pid_bad), .pid_class(pid_class), .pid_type(pid_type),
    .tok_stb(tok_stb), .sof_stb(sof_stb), .addr_hit(addr_hit), .len_err(len_err),
    .tok_addr(tok_addr), .tok_endp(tok_endp), .frame_num(frame_num)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic f, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_first = f; in_last = l;
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic logic [7:0] pidb(input logic [3:0] n);
    return {~n, n};
  endfunction

  function automatic logic [1:0] ecls(input logic [3:0] n);
    case (n[1:0])
      2'b01:   return (n == 4'h5) ? 2'd3 : 2'd0;
      2'b11:   return 2'd1;
      2'b10:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] tok_nib(input int k);
    case (k % 3)
      0:       return 4'h1;
      1:       return 4'h9;
      default: return 4'hD;
    endcase
  endfunction

  task automatic send_tok(input logic [3:0] nib, input logic [6:0] a, input logic [3:0] e, input logic [4:0] c);
    logic [15:0] p;
    p = {c, e, a};
    put(pidb(nib), 1'b1, 1'b0);
    check("R2 token pid ok", pid_ok, 1'b1);
    check("R3 token class", pid_class, ecls(nib));
    put(p[7:0], 1'b0, 1'b0);
    check("R4 no strobe mid payload", tok_stb, 1'b0);
    put(p[15:8], 1'b0, 1'b1);
    ex_addr = a; ex_endp = e;
    check("R4 tok_stb", tok_stb, 1'b1);
    check("R4 tok_addr", tok_addr, a);
    check("R4 tok_endp", tok_endp, e);
    check("R5 addr_hit", addr_hit, (a == dev_addr));
    check("R7 no len_err", len_err, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; dev_addr = 7'h2A;
    in_valid = 1'b0; in_data = 8'h00; in_first = 1'b0; in_last = 1'b0;
    gap(4);
    rst_n = 1'b1;
    gap(3);
    // R1 reset state
    check("R1 strobes", {pid_ok, pid_bad, tok_stb, sof_stb, addr_hit, len_err}, 6'b0);
    check("R1 fields", {tok_addr, tok_endp, frame_num, pid_class, pid_type}, 0);

    // R2 R3 R7: every identifier byte as a one-byte packet
    for (int b = 0; b < 256; b++) begin
      logic [7:0] by;
      logic ok;
      by = b[7:0];
      ok = (by[7:4] == ~by[3:0]) && (by[1:0] != 2'b00);
      put(by, 1'b1, 1'b1);
      check("R2 pid_ok", pid_ok, ok);
      check("R2 pid_bad", pid_bad, !ok);
      check("R3 pid_type", pid_type, by[3:0]);
      if (ok) check("R3 pid_class", pid_class, ecls(by[3:0]));
      check("R7 one-byte token/sof len_err", len_err, ok && (by[1:0] == 2'b01));
      check("R9 no decode", {tok_stb, sof_stb}, 2'b00);
    end
    check("R1 fields untouched by sweep", tok_addr, 7'h00);

    // R4 R5: every address, rotating endpoint and token code
    for (int a = 0; a < 128; a++)
      send_tok(tok_nib(a), a[6:0], 4'((a * 5) % 16), 5'(a % 32));
    for (int e = 0; e < 16; e++)
      send_tok(tok_nib(e), 7'h2A, e[3:0], 5'h1F);
    dev_addr = 7'h00;
    for (int a = 0; a < 128; a += 9)
      send_tok(4'h1, a[6:0], 4'h0, 5'h00);
    dev_addr = 7'h55;

    // R6: frame numbers
    for (int k = 0; k < 64; k++) begin
      logic [10:0] f;
      f = 11'((k * 37) % 2048);
      put(pidb(4'h5), 1'b1, 1'b0);
      check("R3 sof class", pid_class, 2'd3);
      put(f[7:0], 1'b0, 1'b0);
      put({5'h0A, f[10:8]}, 1'b0, 1'b1);
      ex_frame = f;
      check("R6 sof_stb", sof_stb, 1'b1);
      check("R6 frame_num", frame_num, f);
      check("R6 no tok_stb", tok_stb, 1'b0);
      check("R5 no hit on sof", addr_hit, 1'b0);
      check("R6 token fields kept", {tok_addr, tok_endp}, {ex_addr, ex_endp});
    end

    // R7: token cut after first payload byte
    put(pidb(4'h9), 1'b1, 1'b0);
    put(8'h55, 1'b0, 1'b1);
    check("R7 short len_err", len_err, 1'b1);
    check("R7 short no tok_stb", tok_stb, 1'b0);
    check("R7 short addr kept", tok_addr, ex_addr);
    // R7: over-long token
    put(pidb(4'h1), 1'b1, 1'b0);
    put(8'h33, 1'b0, 1'b0);
    put(8'h07, 1'b0, 1'b0);
    check("R7 long no tok_stb", tok_stb, 1'b0);
    check("R7 long no early err", len_err, 1'b0);
    put(8'h99, 1'b0, 1'b1);
    check("R7 long len_err", len_err, 1'b1);
    check("R7 long fields kept", {tok_addr, tok_endp}, {ex_addr, ex_endp});
    // R7: over-long start-of-frame
    put(pidb(4'h5), 1'b1, 1'b0);
    put(8'h12, 1'b0, 1'b0);
    put(8'h03, 1'b0, 1'b0);
    put(8'h44, 1'b0, 1'b1);
    check("R7 long sof len_err", len_err, 1'b1);
    check("R7 long sof frame kept", frame_num, ex_frame);
    // R8: new identifier while a token is open
    put(pidb(4'hD), 1'b1, 1'b0);
    put(8'h21, 1'b0, 1'b0);
    put(pidb(4'h3), 1'b1, 1'b1);
    check("R8 len_err on interrupt", len_err, 1'b1);
    check("R8 new pid_ok", pid_ok, 1'b1);
    check("R8 new class data", pid_class, 2'd1);
    check("R8 fields kept", tok_addr, ex_addr);
    put(pidb(4'h5), 1'b1, 1'b0);
    put(pidb(4'h2), 1'b1, 1'b1);
    check("R8 sof interrupted", len_err, 1'b1);

    // R9: bytes after bad, data and handshake identifiers, and stray bytes
    put(8'h11, 1'b1, 1'b0);
    check("R9 bad pid", pid_bad, 1'b1);
    put(8'h55, 1'b0, 1'b0);
    put(8'h05, 1'b0, 1'b1);
    check("R9 after bad pid", {tok_stb, sof_stb, len_err, addr_hit}, 4'b0);
    put(pidb(4'hB), 1'b1, 1'b0);
    put(8'h55, 1'b0, 1'b0);
    put(8'h05, 1'b0, 1'b1);
    check("R9 after data pid", {tok_stb, sof_stb, len_err}, 3'b0);
    put(pidb(4'hA), 1'b1, 1'b0);
    put(8'h2A, 1'b0, 1'b1);
    check("R9 after handshake", {tok_stb, len_err}, 2'b0);
    put(8'h2A, 1'b0, 1'b1);
    check("R9 stray byte", {pid_ok, pid_bad, tok_stb, len_err}, 4'b0);
    check("R9 fields kept", {tok_addr, tok_endp, frame_num}, {ex_addr, ex_endp, ex_frame});

    // R10: token with idle gaps
    put(pidb(4'h9), 1'b1, 1'b0);
    gap(3);
    put(8'hD5, 1'b0, 1'b0);
    gap(2);
    check("R10 quiet in gap", {tok_stb, len_err}, 2'b0);
    put(8'h02, 1'b0, 1'b1);
    check("R10 gapped tok_stb", tok_stb, 1'b1);
    check("R10 gapped addr", tok_addr, 7'h55);
    check("R10 gapped endp", tok_endp, 4'h5);
    check("R10 gapped hit", addr_hit, 1'b1);
    gap(1);
    check("R4 strobe one cycle", {tok_stb, addr_hit}, 2'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule